// File: doc/BRIEF.md
# Wrapping Effective Address Generator

This block forms the effective address for the indexed and indirect operand modes of an 8-bit CPU with a 16-bit address space. It covers zero-page indexed by X or Y, indexed-indirect through a zero-page pointer offset by X, indirect-indexed through a zero-page pointer with Y added afterwards, and the absolute indirect jump. For each mode it follows the page-wrap behaviour of early silicon. When a sum would normally carry into the next page, the block wraps inside the current page instead and reports which wrap occurred.

The core pulses `start_i` with the mode, the operand bytes and the index registers. The zero-page indexed modes finish on the next clock edge. The indirect modes fetch two pointer bytes, one per cycle, through a synchronous read port whose data returns one cycle after the request. The result arrives with a one-cycle `done_o` strobe, together with a page-cross flag and a two-bit wrap-event code.

Top module: `wq_agen`

## Requirements
- R1: While `rst_ni` is low, `done_o`, `rd_en_o`, `page_cross_o`, `bug_o` and `ea_o` are all zero.
- R2: Mode encoding on `mode_i` is 0 = zero-page,X and 1 = zero-page,Y. For these modes, a start accepted at a clock edge gives `done_o` high after that same edge, with `ea_o` = {0x00, (operand_lo + index) mod 256}. No memory read is made.
- R3: In modes 0 and 1, when operand_lo + index exceeds 255, `bug_o` = 1 (zero-page wrap) and `page_cross_o` = 1. Otherwise both are 0.
- R4: Mode encoding continues with 2 = (zp,X), 3 = (zp),Y and 4 = indirect jump. For these modes the low pointer byte is read in the first cycle after the start edge and the high pointer byte in the second. `rd_en_o` is then low, and `done_o` rises after the fourth edge counted from the start edge. `rd_en_o` is never high while `done_o` is high.
- R5: In mode 2, the read addresses are {0x00, p} and {0x00, (p+1) mod 256}, where p = (operand_lo + X) mod 256. `ea_o` = {second byte, first byte}.
- R6: In mode 2, when operand_lo + X exceeds 255, `bug_o` = 3 (indexed-indirect wrap) and `page_cross_o` = 1. Otherwise both are 0.
- R7: In mode 3, the read addresses are {0x00, operand_lo} and {0x00, (operand_lo+1) mod 256}. `ea_o` = ({second, first} + Y) mod 65536. `page_cross_o` is 1 when the high byte of the sum differs from the pointer's high byte, and `bug_o` = 0.
- R8: In mode 4, the read addresses are {operand_hi, operand_lo} and {operand_hi, (operand_lo+1) mod 256}, and `ea_o` = {second, first}. When operand_lo = 0xFF, `bug_o` = 2 (jump wrap) and `page_cross_o` = 1.
- R9: `bug_o` and `page_cross_o` are zero in every cycle where `done_o` is low. Code values are 0 = none, 1 = zero-page wrap, 2 = jump wrap, 3 = indexed-indirect wrap.
- R10: A start raised while an indirect fetch is in progress is ignored. It produces no extra `done_o` and does not alter the result in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an address computation |
| mode_i | input | 3 | Addressing mode code |
| opnd_lo_i | input | 8 | First operand byte (zero-page base or pointer low) |
| opnd_hi_i | input | 8 | Second operand byte (pointer high, jump mode only) |
| x_i | input | 8 | X index register |
| y_i | input | 8 | Y index register |
| rd_data_i | input | 8 | Read data, valid one cycle after the request |
| rd_en_o | output | 1 | Read request |
| rd_addr_o | output | 16 | Read address |
| ea_o | output | 16 | Effective address, valid with `done_o` |
| done_o | output | 1 | One-cycle completion strobe |
| page_cross_o | output | 1 | A 16-bit sum would have changed the high byte |
| bug_o | output | 2 | Wrap-event code |

## Verification
Each mode is tried with bases and indexes that stay inside the page, with sums that land exactly on 0xFF, and with sums that spill over. This separates a true 8-bit wrap from a carried 16-bit add, and it catches the wrong event code being raised. Pointers at 0xFF in zero page and jump pointers ending in 0xFF show whether the second fetch stays on the same page. Pointer-plus-Y cases that cross a page show that this mode, unlike the others, does carry. A second start injected mid-fetch shows whether a busy request leaks through. A long pseudo-random mix compares every cycle against a behavioural model.

// File: rtl/wq_pkg.sv
package wq_pkg;
  typedef enum logic [2:0] {
    M_ZPX = 3'd0,
    M_ZPY = 3'd1,
    M_IZX = 3'd2,
    M_IZY = 3'd3,
    M_JMP = 3'd4
  } wq_mode_e;

  typedef enum logic [1:0] {
    B_NONE  = 2'd0,
    B_ZPIDX = 2'd1,
    B_JMP   = 2'd2,
    B_IZX   = 2'd3
  } wq_bug_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LO,
    S_HI,
    S_CAP
  } wq_state_e;
endpackage

// File: rtl/wq_add.sv
module wq_add #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] sum_o,
  output logic          cy_o
);
  assign {cy_o, sum_o} = {1'b0, a_i} + {1'b0, b_i};
endmodule

// File: rtl/wq_seq.sv
module wq_seq
  import wq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic busy_o,
  output logic rd_en_o,
  output logic hi_o,
  output logic cap_o
);
  wq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (go_i) state_d = S_LO;
      S_LO:   state_d = S_HI;
      S_HI:   state_d = S_CAP;
      S_CAP:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o  = (state_q != S_IDLE);
  assign rd_en_o = (state_q == S_LO) || (state_q == S_HI);
  assign hi_o    = (state_q == S_HI);
  assign cap_o   = (state_q == S_CAP);
endmodule

// File: rtl/wq_agen.sv
module wq_agen
  import wq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2:0]      mode_i,
  input  logic [DW-1:0]   opnd_lo_i,
  input  logic [DW-1:0]   opnd_hi_i,
  input  logic [DW-1:0]   x_i,
  input  logic [DW-1:0]   y_i,
  input  logic [DW-1:0]   rd_data_i,
  output logic            rd_en_o,
  output logic [2*DW-1:0] rd_addr_o,
  output logic [2*DW-1:0] ea_o,
  output logic            done_o,
  output logic            page_cross_o,
  output logic [1:0]      bug_o
);
  localparam int AW = 2 * DW;

  logic [DW-1:0] idx, zsum, inc_lo, ylo, yhi, lo_byte_q, y_q;
  logic          zcy, inc_cy, ycy, izx_cy_q;
  logic [AW-1:0] ptr_q, ea_d;
  logic          pc_d;
  wq_bug_e       bug_d;
  wq_mode_e      mode_q;
  logic          busy, rd_en, hi_phase, cap, accept, is_zp, is_ind;

  assign is_zp  = (mode_i == M_ZPX) || (mode_i == M_ZPY);
  assign is_ind = (mode_i == M_IZX) || (mode_i == M_IZY) || (mode_i == M_JMP);
  assign accept = start_i && !busy;
  assign idx    = (mode_i == M_ZPY) ? y_i : x_i;

  wq_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (accept && is_ind),
    .busy_o  (busy),
    .rd_en_o (rd_en),
    .hi_o    (hi_phase),
    .cap_o   (cap)
  );

  // base + index, wraps in page
  wq_add #(.DW(DW)) u_idx (.a_i(opnd_lo_i), .b_i(idx), .sum_o(zsum), .cy_o(zcy));
  // second pointer byte address, wraps in page
  wq_add #(.DW(DW)) u_inc (.a_i(ptr_q[DW-1:0]), .b_i(DW'(1)), .sum_o(inc_lo), .cy_o(inc_cy));
  // pointer low + Y, carry goes to high byte
  wq_add #(.DW(DW)) u_yad (.a_i(lo_byte_q), .b_i(y_q), .sum_o(ylo), .cy_o(ycy));

  assign yhi = rd_data_i + DW'(ycy);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= M_ZPX;
      y_q       <= '0;
      izx_cy_q  <= 1'b0;
      ptr_q     <= '0;
      lo_byte_q <= '0;
    end else begin
      if (accept && is_ind) begin
        mode_q   <= wq_mode_e'(mode_i);
        y_q      <= y_i;
        izx_cy_q <= zcy && (mode_i == M_IZX);
        ptr_q    <= {(mode_i == M_JMP) ? opnd_hi_i : {DW{1'b0}},
                     (mode_i == M_IZX) ? zsum : opnd_lo_i};
      end
      if (hi_phase) lo_byte_q <= rd_data_i;
    end
  end

  assign rd_en_o   = rd_en;
  assign rd_addr_o = hi_phase ? {ptr_q[AW-1:DW], inc_lo} : ptr_q;

  always_comb begin
    ea_d  = {rd_data_i, lo_byte_q};
    pc_d  = 1'b0;
    bug_d = B_NONE;
    unique case (mode_q)
      M_IZX: begin
        pc_d  = izx_cy_q;
        bug_d = izx_cy_q ? B_IZX : B_NONE;
      end
      M_IZY: begin
        ea_d = {yhi, ylo};
        pc_d = ycy;
      end
      M_JMP: begin
        pc_d  = inc_cy;
        bug_d = inc_cy ? B_JMP : B_NONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_o         <= '0;
      done_o       <= 1'b0;
      page_cross_o <= 1'b0;
      bug_o        <= B_NONE;
    end else if (cap) begin
      ea_o         <= ea_d;
      done_o       <= 1'b1;
      page_cross_o <= pc_d;
      bug_o        <= bug_d;
    end else if (accept && is_zp) begin
      ea_o         <= {{DW{1'b0}}, zsum};
      done_o       <= 1'b1;
      page_cross_o <= zcy;
      bug_o        <= zcy ? B_ZPIDX : B_NONE;
    end else begin
      done_o       <= 1'b0;
      page_cross_o <= 1'b0;
      bug_o        <= B_NONE;
    end
  end

  AST_HI_SAME_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o && !hi_phase |=> rd_en_o && rd_addr_o[AW-1:DW] == $past(rd_addr_o[AW-1:DW])); // R8
  AST_HI_LO_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o && !hi_phase |=> rd_addr_o[DW-1:0] == DW'($past(rd_addr_o[DW-1:0]) + 1'b1)); // R5
  AST_ZP_WRAP_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && bug_o == B_ZPIDX |-> ea_o[AW-1:DW] == '0 && page_cross_o); // R3
  AST_JMP_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && bug_o == B_JMP |-> page_cross_o); // R8
  AST_QUIET_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> bug_o == B_NONE && !page_cross_o); // R9
  AST_NO_RD_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_en_o); // R4
endmodule

// File: tb/wq_agen_tb.sv
module wq_agen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [7:0]  opnd_lo_i = '0, opnd_hi_i = '0, x_i = '0, y_i = '0, rd_data_i = '0;
  logic        rd_en_o, done_o, page_cross_o;
  logic [15:0] rd_addr_o, ea_o;
  logic [1:0]  bug_o;

  int nvec = 0, nbad = 0, cyc = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  wq_agen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .opnd_lo_i(opnd_lo_i), .opnd_hi_i(opnd_hi_i), .x_i(x_i), .y_i(y_i),
    .rd_data_i(rd_data_i), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
    .ea_o(ea_o), .done_o(done_o), .page_cross_o(page_cross_o), .bug_o(bug_o)
  );

  function automatic int memf(input int a);
    return ((((a & 255) * 7) ^ ((a >> 8) & 255)) + 91) & 255;
  endfunction

  always @(posedge clk) if (rd_en_o) rd_data_i <= 8'(memf(int'(rd_addr_o)));

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nbad++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      summary();
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[23:16]);
  endfunction

  task automatic run_op(input int m, input int lo, input int hi, input int x, input int y, input bit inj);
    int ea, pc, bug, lat, a1, a2, b1, b2, p, s, ptr;
    string rt, rb;
    a1 = 0; a2 = 0; ea = 0; pc = 0; bug = 0; lat = 4;
    case (m)
      0, 1: begin
        s = lo + ((m == 1) ? y : x);
        ea = s & 255; pc = (s > 255); bug = pc ? 1 : 0; lat = 1;
        rt = "R2"; rb = "R3";
      end
      2: begin
        p = (lo + x) & 255; a1 = p; a2 = (p + 1) & 255;
        ea = memf(a2) * 256 + memf(a1);
        pc = ((lo + x) > 255); bug = pc ? 3 : 0;
        rt = "R5"; rb = "R6";
      end
      3: begin
        a1 = lo; a2 = (lo + 1) & 255;
        b1 = memf(a1); b2 = memf(a2); ptr = b2 * 256 + b1;
        s = ptr + y; ea = s & 65535;
        pc = (((s >> 8) & 255) != (ptr >> 8)); bug = 0;
        rt = "R7"; rb = "R7";
      end
      default: begin
        a1 = hi * 256 + lo; a2 = hi * 256 + ((lo + 1) & 255);
        ea = memf(a2) * 256 + memf(a1);
        pc = (lo == 255); bug = pc ? 2 : 0;
        rt = "R8"; rb = "R8";
      end
    endcase
    @(negedge clk);
    start_i = 1'b1; mode_i = 3'(m); opnd_lo_i = 8'(lo); opnd_hi_i = 8'(hi);
    x_i = 8'(x); y_i = 8'(y);
    for (int k = 1; k <= lat + 1; k++) begin
      @(posedge clk); #1;
      if (k == 1) begin
        if (inj) begin
          start_i = 1'b1; mode_i = 3'd0; opnd_lo_i = 8'hF7; x_i = 8'h33; y_i = 8'h91;
        end else start_i = 1'b0;
      end else if (k == 2) start_i = 1'b0;
      if (k == lat) begin
        chk("R4 done", int'(done_o), 1);
        chk({rt, " ea"}, int'(ea_o), ea);
        chk({rb, " page_cross"}, int'(page_cross_o), pc);
        chk({rb, " bug"}, int'(bug_o), bug);
      end else begin
        chk(inj ? "R10 no done" : "R4 no done", int'(done_o), 0);
        chk("R9 bug quiet", int'(bug_o), 0);
        chk("R9 pc quiet", int'(page_cross_o), 0);
      end
      if (lat == 4 && k == 1) begin
        chk("R4 rd lo", int'(rd_en_o), 1);
        chk({rt, " addr lo"}, int'(rd_addr_o), a1);
      end else if (lat == 4 && k == 2) begin
        chk("R4 rd hi", int'(rd_en_o), 1);
        chk({rt, " addr hi"}, int'(rd_addr_o), a2);
      end else begin
        chk(lat == 1 ? "R2 no read" : "R4 no read", int'(rd_en_o), 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 done", int'(done_o), 0);
    chk("R1 rd_en", int'(rd_en_o), 0);
    chk("R1 ea", int'(ea_o), 0);
    chk("R1 bug", int'(bug_o), 0);
    chk("R1 pc", int'(page_cross_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    run_op(0, 8'h10, 0, 8'h05, 0, 1'b0);
    run_op(0, 8'hF0, 0, 8'h20, 0, 1'b0);
    run_op(1, 8'hFF, 0, 0, 8'h00, 1'b0);
    run_op(1, 8'hFF, 0, 0, 8'h01, 1'b0);
    run_op(2, 8'h40, 0, 8'h02, 0, 1'b0);
    run_op(2, 8'hFE, 0, 8'h03, 0, 1'b0);
    run_op(2, 8'hFF, 0, 8'h00, 0, 1'b0);
    run_op(3, 8'h20, 0, 0, 8'h04, 1'b0);
    run_op(3, 8'hFF, 0, 0, 8'hFF, 1'b0);
    run_op(4, 8'hFF, 8'h12, 0, 0, 1'b0);
    run_op(4, 8'hFE, 8'h30, 0, 0, 1'b0);
    run_op(2, 8'hF9, 0, 8'h10, 0, 1'b1);
    run_op(4, 8'h7C, 8'h55, 0, 0, 1'b1);
    for (int i = 0; i < 300; i++) begin
      int m;
      m = rnd() % 5;
      run_op(m, rnd(), rnd(), rnd(), rnd(), (m >= 2) && (rnd() < 40));
    end
    repeat (2) @(posedge clk);
    summary();
  end
endmodule